// File: doc/BRIEF.md
# Stored Image Header and CRC Checker

This block vets a configuration image before anything is loaded from it. It takes the image one byte per accepted transfer, starting at image offset 0. It checks a fixed three-letter tag, the declared total length and a variable-length name field. It then finds the payload and computes a CRC-32 over it. While the payload passes, it also walks a chain of embedded string-length bytes and checks each one against a limit. At the end it reports a two-bit result code together with the payload offset and payload length it derived.

A `start` pulse arms the checker and clears the previous result. The checker raises `in_ready` and consumes bytes until one of two things happens. A header field fails, and the checker stops at once. Or the last byte of the declared length arrives. One cycle after the final accepted byte, the result appears. It stays valid until the next `start`.

Top module: `imgchk_top`

## Requirements
- R1: While reset is asserted and directly after it, `in_ready` and `res_valid` are both low.
- R2: A `start` pulse clears `res_valid` and raises `in_ready` in the next cycle.
- R3: Image bytes 0, 1 and 2 must be 0x43, 0x46 and 0x47. On a mismatch the result code is 1 (format). It is issued once byte 11 is accepted, and no further byte is accepted. This check takes precedence over R4.
- R4: Bytes 8..11 hold the total image length, big-endian. A length that is zero, below MIN_LEN (default 0x133A4) or above MAX_LEN (default 0x7FFFF) yields code 2 (length) after byte 11, and no further byte is accepted. Lengths equal to either bound are accepted.
- R5: The name length N is byte 13, the low byte of the 16-bit field at offset 12. If the total length is below 14+N, the result is code 2 after byte 13. A length equal to 14+N is allowed and gives an empty payload.
- R6: `pay_off` reports 14+N and `pay_len` reports the total length minus 14 minus N.
- R7: Bytes 4..7 hold the stored CRC, big-endian. It is compared with the CRC-32 of the payload: reflected polynomial 0xEDB88320, register preset to all ones, result inverted. A mismatch gives code 3, which takes precedence over R8.
- R8: Within the payload, the byte at offset 15 is a length L0 with L0 ≤ 32. Every length byte at position p places the next one at p+L+3. The three following length bytes must each lie in 1..33. If any of the four is out of range, or any does not fall inside the payload, the result is code 1.
- R9: An image that passes every check yields code 0.
- R10: The result is valid one cycle after the final accepted byte, at image index length−1. From that point `in_ready` is low. The result, code and payload fields hold until the next `start`.
- R11: Before the first `start` after reset, `in_ready` stays low and input bytes are ignored. A `start` during a stream abandons that stream and restarts at image byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms a new check and clears the previous result |
| in_valid | input | 1 | Image byte present on `in_data` |
| in_data | input | 8 | Image byte, in image order from offset 0 |
| in_ready | output | 1 | High while the checker accepts bytes |
| res_valid | output | 1 | Result fields are valid |
| res_code | output | 2 | 0 pass, 1 format, 2 length, 3 CRC |
| pay_off | output | LEN_W | Payload offset, 14 plus the name length |
| pay_len | output | LEN_W | Payload length in bytes |

## Verification
A byte counter that is off by one shows up at the ports in one of two ways. Either `in_ready` drops one cycle early or late compared with the declared length, or a header field is taken from the wrong byte, which gives a wrong code on the very next result. A fault in the CRC register or the length-chain walker stays hidden until the end of the stream. It then appears as a pass or fail code that differs from the expected one. The bench therefore counts the bytes accepted and checks both the cycle in which the result appears and the code in every scenario. That includes the bound values and cases where two failures are present together, which expose the precedence between them.

// File: rtl/imgchk_pkg.sv
package imgchk_pkg;

  typedef enum logic [1:0] {
    RC_PASS   = 2'd0,
    RC_FORMAT = 2'd1,
    RC_LENGTH = 2'd2,
    RC_CRC    = 2'd3
  } res_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } chk_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  // One byte through a reflected CRC-32 register, LSB first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/imgchk_crc.sv
module imgchk_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  import imgchk_pkg::*;

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr) begin
      crc_d = '1;
    end else if (en) begin
      crc_d = crc32_byte(crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else begin
      crc_q <= crc_d;
    end
  end

  assign crc_out = ~crc_q;

endmodule

// File: rtl/imgchk_walk.sv
module imgchk_walk #(
  parameter int LIMIT     = 32,
  parameter int COUNT     = 4,
  parameter int FIRST_OFF = 15,
  parameter int SKIP      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic       ok
);
  localparam int GAP_W  = 9;
  localparam int SEEN_W = $clog2(COUNT + 1);

  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [SEEN_W-1:0] seen_q, seen_d;
  logic              bad_q, bad_d;
  logic              out_of_range;

  // First length byte may be 0..LIMIT; later ones carry a terminator: 1..LIMIT+1.
  always_comb begin
    if (seen_q == '0) begin
      out_of_range = ({1'b0, din} > 9'(LIMIT));
    end else begin
      out_of_range = (din == 8'd0) || ({1'b0, din} > 9'(LIMIT + 1));
    end
  end

  always_comb begin
    gap_d  = gap_q;
    seen_d = seen_q;
    bad_d  = bad_q;
    if (clr) begin
      gap_d  = GAP_W'(FIRST_OFF);
      seen_d = '0;
      bad_d  = 1'b0;
    end else if (en && (seen_q < SEEN_W'(COUNT))) begin
      if (gap_q == '0) begin
        seen_d = seen_q + 1'b1;
        gap_d  = GAP_W'(din) + GAP_W'(SKIP - 1);
        bad_d  = bad_q | out_of_range;
      end else begin
        gap_d = gap_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GAP_W'(FIRST_OFF);
      seen_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      gap_q  <= gap_d;
      seen_q <= seen_d;
      bad_q  <= bad_d;
    end
  end

  assign ok = (seen_q == SEEN_W'(COUNT)) && !bad_q;

endmodule

// File: rtl/imgchk_top.sv
module imgchk_top #(
  parameter int                LEN_W     = 32,
  parameter logic [LEN_W-1:0]  MIN_LEN   = LEN_W'(32'h0001_33A4),
  parameter logic [LEN_W-1:0]  MAX_LEN   = LEN_W'(32'h0007_FFFF),
  parameter logic [23:0]       TAG       = 24'h43_46_47,
  parameter int                STR_LIMIT = 32,
  parameter int                STR_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             res_valid,
  output logic [1:0]       res_code,
  output logic [LEN_W-1:0] pay_off,
  output logic [LEN_W-1:0] pay_len
);
  import imgchk_pkg::*;

  localparam int TAG_END      = 2;
  localparam int CRC_FIRST    = 4;
  localparam int CRC_LAST     = 7;
  localparam int LEN_FIRST    = 8;
  localparam int LEN_LAST     = 11;
  localparam int NAME_LEN_POS = 13;
  localparam int HDR_BYTES    = 14;
  localparam int STR_FIRST    = 15;
  localparam int STR_SKIP     = 3;

  chk_state_e       state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             tag_ok_q, tag_ok_d;
  logic [31:0]      crc_ref_q, crc_ref_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] off_q, off_d;
  logic             early_q, early_d;
  res_code_e        ecode_q, ecode_d;
  logic             rv_q, rv_d;
  res_code_e        rc_q, rc_d;

  logic             accept;
  logic             pay_byte;
  logic             last_byte;
  logic [7:0]       tag_byte;
  logic [LEN_W-1:0] len_nx;
  logic             len_bad;
  logic [31:0]      crc_calc;
  logic             walk_ok;

  assign in_ready  = (state_q == ST_RUN);
  assign accept    = in_valid && in_ready;
  assign last_byte = (cnt_q == len_q - 1'b1);
  assign pay_byte  = accept && (cnt_q > LEN_W'(NAME_LEN_POS)) && (cnt_q >= off_q);
  assign len_nx    = {len_q[LEN_W-9:0], in_data};
  assign len_bad   = (len_nx == '0) || (len_nx < MIN_LEN) || (len_nx > MAX_LEN);

  always_comb begin
    case (cnt_q[1:0])
      2'd0:    tag_byte = TAG[23:16];
      2'd1:    tag_byte = TAG[15:8];
      default: tag_byte = TAG[7:0];
    endcase
  end

  imgchk_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .en      (pay_byte),
    .din     (in_data),
    .crc_out (crc_calc)
  );

  imgchk_walk #(
    .LIMIT     (STR_LIMIT),
    .COUNT     (STR_COUNT),
    .FIRST_OFF (STR_FIRST),
    .SKIP      (STR_SKIP)
  ) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .en    (pay_byte),
    .din   (in_data),
    .ok    (walk_ok)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    tag_ok_d  = tag_ok_q;
    crc_ref_d = crc_ref_q;
    len_d     = len_q;
    off_d     = off_q;
    early_d   = early_q;
    ecode_d   = ecode_q;
    rv_d      = rv_q;
    rc_d      = rc_q;
    if (start) begin
      state_d   = ST_RUN;
      cnt_d     = '0;
      tag_ok_d  = 1'b1;
      crc_ref_d = '0;
      len_d     = '0;
      off_d     = LEN_W'(HDR_BYTES);
      early_d   = 1'b0;
      ecode_d   = RC_PASS;
      rv_d      = 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (accept) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q <= LEN_W'(TAG_END)) begin
              tag_ok_d = tag_ok_q && (in_data == tag_byte);
            end
            if ((cnt_q >= LEN_W'(CRC_FIRST)) && (cnt_q <= LEN_W'(CRC_LAST))) begin
              crc_ref_d = {crc_ref_q[23:0], in_data};
            end
            if ((cnt_q >= LEN_W'(LEN_FIRST)) && (cnt_q <= LEN_W'(LEN_LAST))) begin
              len_d = len_nx;
            end
            if (cnt_q == LEN_W'(LEN_LAST)) begin
              if (!tag_ok_q) begin
                state_d = ST_FIN;
                early_d = 1'b1;
                ecode_d = RC_FORMAT;
              end else if (len_bad) begin
                state_d = ST_FIN;
                early_d = 1'b1;
                ecode_d = RC_LENGTH;
              end
            end else if (cnt_q == LEN_W'(NAME_LEN_POS)) begin
              off_d = LEN_W'(HDR_BYTES) + LEN_W'(in_data);
              if (len_q < off_d) begin
                state_d = ST_FIN;
                early_d = 1'b1;
                ecode_d = RC_LENGTH;
              end else if (last_byte) begin
                state_d = ST_FIN;
              end
            end else if ((cnt_q > LEN_W'(NAME_LEN_POS)) && last_byte) begin
              state_d = ST_FIN;
            end
          end
        end
        ST_FIN: begin
          state_d = ST_IDLE;
          rv_d    = 1'b1;
          if (early_q) begin
            rc_d = ecode_q;
          end else if (crc_calc != crc_ref_q) begin
            rc_d = RC_CRC;
          end else if (!walk_ok) begin
            rc_d = RC_FORMAT;
          end else begin
            rc_d = RC_PASS;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      tag_ok_q  <= 1'b0;
      crc_ref_q <= '0;
      len_q     <= '0;
      off_q     <= LEN_W'(HDR_BYTES);
      early_q   <= 1'b0;
      ecode_q   <= RC_PASS;
      rv_q      <= 1'b0;
      rc_q      <= RC_PASS;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      tag_ok_q  <= tag_ok_d;
      crc_ref_q <= crc_ref_d;
      len_q     <= len_d;
      off_q     <= off_d;
      early_q   <= early_d;
      ecode_q   <= ecode_d;
      rv_q      <= rv_d;
      rc_q      <= rc_d;
    end
  end

  assign res_valid = rv_q;
  assign res_code  = rc_q;
  assign pay_off   = off_q;
  assign pay_len   = len_q - off_q;

endmodule

// File: rtl/imgchk_sva.sv
module imgchk_sva #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_ready,
  input logic             res_valid,
  input logic [1:0]       res_code,
  input logic [LEN_W-1:0] pay_off
);

  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!res_valid && in_ready));

  assert_ready_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(start));

  assert_no_accept_with_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !start) |=> (res_valid && $stable(res_code) && $stable(pay_off)));

  assert_pass_offset_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_code == 2'd0)) |-> ((pay_off >= LEN_W'(14)) && (pay_off <= LEN_W'(269))));

endmodule

bind imgchk_top imgchk_sva #(.LEN_W(LEN_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .res_code  (res_code),
  .pay_off   (pay_off)
);

// File: tb/imgchk_top_test.sv
module imgchk_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        res_valid;
  logic [1:0]  res_code;
  logic [31:0] pay_off;
  logic [31:0] pay_len;

  always #10 clk = ~clk;

  imgchk_top #(
    .MIN_LEN (32'd40),
    .MAX_LEN (32'd400)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .res_valid (res_valid),
    .res_code  (res_code),
    .pay_off   (pay_off),
    .pay_len   (pay_len)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] img [0:511];
  int         img_n;

  typedef struct {
    logic [1:0]  code;
    logic [31:0] off;
    logic [31:0] len;
    bit          geom;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int first, input int stop);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int k = first; k < stop; k++) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ img[k][b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return ~c;
  endfunction

  task automatic put32(input int at, input logic [31:0] v);
    img[at]   = v[31:24];
    img[at+1] = v[23:16];
    img[at+2] = v[15:8];
    img[at+3] = v[7:0];
  endtask

  // Good-format image: name of nlen bytes, payload of plen bytes, chain lengths a..d.
  task automatic build(input int nlen, input int plen, input int a, input int b,
                       input int c, input int d);
    int total;
    int base;
    int pos;
    total = 14 + nlen + plen;
    img_n = total;
    img[0] = 8'h43; img[1] = 8'h46; img[2] = 8'h47; img[3] = 8'h00;
    img[12] = 8'h00;
    img[13] = 8'(nlen);
    for (int k = 0; k < nlen; k++) img[14+k] = 8'(8'h61 + k);
    base = 14 + nlen;
    for (int k = 0; k < plen; k++) img[base+k] = 8'((k * 7 + 3) & 255);
    pos = 15;
    if (pos < plen) img[base+pos] = 8'(a);
    pos = pos + a + 3;
    if (pos < plen) img[base+pos] = 8'(b);
    pos = pos + b + 3;
    if (pos < plen) img[base+pos] = 8'(c);
    pos = pos + c + 3;
    if (pos < plen) img[base+pos] = 8'(d);
    put32(8, 32'(total));
    put32(4, ref_crc(base, total));
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 in_ready after start", 32'(in_ready), 32'd1);
    chk("R2 result cleared by start", 32'(res_valid), 32'd0);
  endtask

  task automatic send(input logic [1:0] code, input int acc_exp, input bit geom, input string req);
    exp_t e;
    int   acc;
    bit   stopped;
    e.code = code;
    e.off  = 32'd14 + 32'(img[13]);
    e.len  = {img[8], img[9], img[10], img[11]} - e.off;
    e.geom = geom;
    e.req  = req;
    exp_q.push_back(e);
    acc     = 0;
    stopped = 1'b0;
    for (int k = 0; k < img_n; k++) begin
      @(negedge clk);
      if (!in_ready) begin
        stopped = 1'b1;
        break;
      end
      in_valid = 1'b1;
      in_data  = img[k];
      @(posedge clk);
      acc++;
    end
    if (!stopped) @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R10 ready low after final byte"}, 32'(in_ready), 32'd0);
    chk({req, " R10 no result in first cycle"}, 32'(res_valid), 32'd0);
    chk({req, " bytes accepted"}, 32'(acc), 32'(acc_exp));
    @(negedge clk);
    chk({req, " R10 result one cycle later"}, 32'(res_valid), 32'd1);
  endtask

  // Scoreboard monitor
  initial begin : monitor
    bit seen;
    exp_t e;
    seen = 1'b0;
    forever begin
      @(negedge clk);
      if (res_valid && !seen) begin
        seen = 1'b1;
        if (exp_q.size() == 0) begin
          chk("R10 unexpected result", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          chk({e.req, " code"}, 32'(res_code), 32'(e.code));
          if (e.geom) begin
            chk({e.req, " R6 pay_off"}, pay_off, e.off);
            chk({e.req, " R6 pay_len"}, pay_len, e.len);
          end
        end
      end
      if (!res_valid) seen = 1'b0;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stimulus
    rst_n    = 1'b0;
    start    = 1'b0;
    in_valid = 1'b1;
    in_data  = 8'h55;
    repeat (3) @(negedge clk);
    chk("R1 in_ready in reset", 32'(in_ready), 32'd0);
    chk("R1 res_valid in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 res_valid after reset", 32'(res_valid), 32'd0);
    chk("R11 no accept before start", 32'(in_ready), 32'd0);
    in_valid = 1'b0;

    // R9 clean image
    build(4, 50, 5, 6, 4, 3);
    do_start();
    send(2'd0, 68, 1'b1, "R9 good image");
    repeat (10) @(negedge clk);
    chk("R10 result held", 32'(res_valid), 32'd1);
    chk("R10 code held", 32'(res_code), 32'd0);

    // R3 tag mismatch
    build(4, 50, 5, 6, 4, 3);
    img[1] = 8'h58;
    do_start();
    send(2'd1, 12, 1'b0, "R3 bad tag");

    // R3 precedence over a zero length
    put32(8, 32'd0);
    do_start();
    send(2'd1, 12, 1'b0, "R3 tag before length");

    // R4 length bounds
    build(4, 50, 5, 6, 4, 3);
    put32(8, 32'd0);
    do_start();
    send(2'd2, 12, 1'b0, "R4 zero length");

    build(4, 50, 5, 6, 4, 3);
    put32(8, 32'd39);
    do_start();
    send(2'd2, 12, 1'b0, "R4 below minimum");

    build(4, 50, 5, 6, 4, 3);
    put32(8, 32'd401);
    do_start();
    send(2'd2, 12, 1'b0, "R4 above maximum");

    build(4, 382, 5, 6, 4, 3);
    do_start();
    send(2'd0, 400, 1'b1, "R4 maximum accepted");

    build(0, 26, 0, 1, 1, 1);
    do_start();
    send(2'd1, 40, 1'b1, "R4 minimum accepted R8 chain truncated");

    // R5 name longer than image
    build(4, 50, 5, 6, 4, 3);
    img[13] = 8'd60;
    do_start();
    send(2'd2, 14, 1'b0, "R5 name overruns length");

    // R5 boundary: empty payload, stored CRC no longer matches
    build(4, 50, 5, 6, 4, 3);
    img[13] = 8'd54;
    do_start();
    send(2'd3, 68, 1'b1, "R5 empty payload allowed");

    // R7 CRC mismatch
    build(4, 50, 5, 6, 4, 3);
    img[20] = img[20] ^ 8'h01;
    do_start();
    send(2'd3, 68, 1'b1, "R7 corrupted payload");

    build(4, 50, 33, 6, 4, 3);
    img[20] = img[20] ^ 8'h01;
    do_start();
    send(2'd3, 68, 1'b1, "R7 precedence over chain");

    // R8 chain limits
    build(4, 50, 33, 6, 4, 3);
    do_start();
    send(2'd1, 68, 1'b1, "R8 first length 33");

    build(4, 60, 32, 1, 1, 1);
    do_start();
    send(2'd0, 78, 1'b1, "R8 first length 32");

    build(4, 50, 5, 0, 4, 3);
    do_start();
    send(2'd1, 68, 1'b1, "R8 zero later length");

    build(4, 50, 5, 6, 4, 33);
    do_start();
    send(2'd0, 68, 1'b1, "R8 later length 33");

    build(4, 50, 5, 6, 4, 34);
    do_start();
    send(2'd1, 68, 1'b1, "R8 later length 34");

    // R11 restart mid-stream
    build(4, 50, 5, 6, 4, 3);
    do_start();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = img[k];
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    do_start();
    send(2'd0, 68, 1'b1, "R11 restart mid-stream");

    repeat (3) @(negedge clk);
    chk("R10 all results delivered", 32'(exp_q.size()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule